// File: doc/BRIEF.md
# VLAN Tag Insert and Strip

This block sits on the byte path of an Ethernet MAC and handles IEEE 802.1Q tags in both directions. Frames travel as byte streams with valid/ready handshakes. A start marker flags the first byte of a frame and an end marker flags the last byte. On the transmit side, a tag-insert control and a 16-bit tag value are presented together with the start byte. When the control is set, the block adds four bytes after the two 6-byte address fields: the tag protocol identifier 0x8100, then the tag value. Upstream is held off while those bytes go out.

On the receive side, de-tagging has its own enable. When the enable is set and bytes 12 and 13 of a frame read 0x8100, the block removes bytes 12 to 15 from the delivered frame. It then reports a tag-hit flag and the removed 16-bit tag as side-band outputs. All other frames pass through unchanged.

The tag value uses the usual layout: user priority in bits 15:13, the canonical format indicator in bit 12, and the VLAN ID in bits 11:0. The upper VLAN ID nibble therefore sits in the low nibble of the first tag byte on the wire. Receive frames that carry the 0x8100 type are assumed to extend past byte 15. CRC, padding and descriptors are handled elsewhere.

Top module: `vlan_tag_unit`

## Requirements
- R1: On transmit, when the tag-insert control sampled with the start byte is 1 and the frame has a byte at index 12, output bytes 12 and 13 are 0x81 then 0x00. The input bytes from index 12 onward follow four positions later.
- R2: On transmit with insertion, output bytes 14 and 15 are the tag value, bits 15:8 first, then bits 7:0.
- R3: On transmit with the control at 0, the frame leaves unchanged and with no added delay: in every cycle the output valid and data equal the input valid and data.
- R4: On transmit with the control at 1, a frame of 12 bytes or fewer leaves unchanged.
- R5: On receive, with de-tagging enabled (enable = 1), when input bytes 12 and 13 are 0x81 and 0x00, input bytes 12 to 15 are absent from the output. All other bytes keep their order.
- R6: After such a removal, on the output end-of-frame beat the tag-hit flag is 1 and the tag output equals input byte 14 in bits 15:8 and input byte 15 in bits 7:0.
- R7: On receive, with de-tagging disabled (enable = 0) or with a type other than 0x8100, the frame is delivered unchanged and the tag-hit flag and tag value read 0 on the end-of-frame beat. With de-tagging disabled the path adds no delay.
- R8: A receive frame whose last byte has index 13 or lower is delivered unchanged with the tag-hit flag at 0, whatever its bytes 12 and 13 hold.
- R9: With output ready held low in any pattern and input valid gaps, neither path loses, repeats or reorders a byte. Start and end markers appear only on the first and last output byte.
- R10: While reset is asserted and after it is released, both output valids are 0, the tag-hit flag and the tag value are 0, and input ready follows output ready. A reset in the middle of a frame leaves no residue.
- R11: During a transmit insertion, the input ready is 0 for exactly four output beats of that frame, given a sink that is always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_valid | input | 1 | Transmit input byte valid |
| tx_in_sof | input | 1 | First byte of transmit frame |
| tx_in_eof | input | 1 | Last byte of transmit frame |
| tx_in_tag_en | input | 1 | Insert a tag in this frame, sampled with the start byte |
| tx_in_tag | input | 16 | Tag value to insert, sampled with the start byte |
| tx_in_ready | output | 1 | Transmit input accepted |
| tx_out_data | output | 8 | Transmit output byte |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_sof | output | 1 | First byte of outgoing transmit frame |
| tx_out_eof | output | 1 | Last byte of outgoing transmit frame |
| tx_out_ready | input | 1 | Downstream can accept a transmit byte |
| rx_strip_en | input | 1 | De-tagging enable, 1 enables |
| rx_in_data | input | 8 | Receive input byte |
| rx_in_valid | input | 1 | Receive input byte valid |
| rx_in_sof | input | 1 | First byte of receive frame |
| rx_in_eof | input | 1 | Last byte of receive frame |
| rx_in_ready | output | 1 | Receive input accepted |
| rx_out_data | output | 8 | Receive output byte |
| rx_out_valid | output | 1 | Receive output byte valid |
| rx_out_sof | output | 1 | First byte of delivered receive frame |
| rx_out_eof | output | 1 | Last byte of delivered receive frame |
| rx_out_ready | input | 1 | Downstream can accept a receive byte |
| rx_tag_hit | output | 1 | A tag was removed from the current frame |
| rx_tag | output | 16 | Value of the removed tag |

## Verification
The bench builds the block with its defaults: 6-byte addresses, so the tag sits at byte 12, and the identifier 0x8100. Short frames of 12, 13 and 14 bytes therefore land exactly on the edges where insertion starts and where the receive path has to hold byte 12 before it can decide. Frames of 17 to 40 bytes cover the shortest strip and the longer runs. Some frames run under stall patterns that hit the hold, flush and drop phases. Near-miss type values such as 0x8101 and 0x0081 reach the flush path, in which the held byte is emitted late.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

  typedef enum logic [1:0] {
    RX_PASS = 2'd0,
    RX_HOLD = 2'd1,
    RX_DROP = 2'd2
  } rx_st_e;

  // Byte k of the four inserted bytes: identifier high, low, tag high, low.
  function automatic logic [7:0] tag_field_byte(input logic [15:0] tpid,
                                                input logic [15:0] tag,
                                                input logic [1:0]  k);
    logic [31:0] field;
    field = {tpid, tag};
    return field[8*(3-k) +: 8];
  endfunction

endpackage

// File: rtl/vtag_pos_cnt.sv
module vtag_pos_cnt #(
  parameter int MAX = 16,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         last,
  output logic [W-1:0] pos
);

  logic [W-1:0] pos_d;

  always_comb begin
    pos_d = pos;
    if (last)
      pos_d = '0;
    else if (pos != W'(MAX))
      pos_d = pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (adv)
      pos <= pos_d;
  end

endmodule

// File: rtl/vtag_tx_insert.sv
module vtag_tx_insert
  import vtag_pkg::*;
#(
  parameter int          HDR  = 12,
  parameter logic [15:0] TPID = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_tag_en,
  input  logic [15:0] in_tag,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_sof,
  output logic        out_eof,
  input  logic        out_ready
);

  localparam int TAG_BYTES = 4;
  localparam int PMAX      = HDR + TAG_BYTES;
  localparam int CW        = $clog2(PMAX + 1);
  localparam int IW        = $clog2(TAG_BYTES + 1);

  logic [CW-1:0] pos;
  logic [IW-1:0] ins_idx, ins_idx_d;
  logic          mode_q, mode_d;
  logic [15:0]   tag_q, tag_d;
  logic          inserting;
  logic          in_acc;

  assign inserting = mode_q && (pos == CW'(HDR)) && (ins_idx != IW'(TAG_BYTES));
  assign in_acc    = in_valid && in_ready;

  vtag_pos_cnt #(.MAX(PMAX), .W(CW)) u_pos (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (in_acc),
    .last (in_eof),
    .pos  (pos)
  );

  always_comb begin
    in_ready  = out_ready && !inserting;
    out_valid = inserting ? 1'b1 : in_valid;
    out_data  = inserting ? tag_field_byte(TPID, tag_q, ins_idx[1:0]) : in_data;
    out_sof   = !inserting && in_sof;
    out_eof   = !inserting && in_eof;
  end

  always_comb begin
    mode_d    = mode_q;
    tag_d     = tag_q;
    ins_idx_d = ins_idx;
    if (inserting && out_ready)
      ins_idx_d = ins_idx + 1'b1;
    if (in_acc && in_sof) begin
      mode_d = in_tag_en;
      tag_d  = in_tag;
    end
    if (in_acc && in_eof)
      ins_idx_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      tag_q   <= '0;
      ins_idx <= '0;
    end else begin
      mode_q  <= mode_d;
      tag_q   <= tag_d;
      ins_idx <= ins_idx_d;
    end
  end

  AST_TX_TPID_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (inserting && out_ready && ins_idx == '0) |=> (out_valid && out_data == TPID[7:0])); // R1

  AST_TX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && inserting) |=> (out_valid && $stable(out_data))); // R9

  AST_TX_INS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (inserting && out_ready && ins_idx != IW'(TAG_BYTES - 1)) |=> !in_ready); // R11

endmodule

// File: rtl/vtag_rx_strip.sv
module vtag_rx_strip
  import vtag_pkg::*;
#(
  parameter int          HDR  = 12,
  parameter logic [15:0] TPID = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strip_en,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_sof,
  output logic        out_eof,
  input  logic        out_ready,
  output logic        tag_hit,
  output logic [15:0] tag_val
);

  localparam int TAG_BYTES = 4;
  localparam int PMAX      = HDR + TAG_BYTES;
  localparam int CW        = $clog2(PMAX + 1);

  rx_st_e        st, st_d;
  logic [CW-1:0] pos;
  logic [7:0]    hold_q, hold_d;
  logic          hit_d;
  logic [15:0]   tag_d;
  logic          tpid_match;
  logic          in_acc;

  assign in_acc     = in_valid && in_ready;
  assign tpid_match = (hold_q == TPID[15:8]) && (in_data == TPID[7:0]) && !in_eof;

  vtag_pos_cnt #(.MAX(PMAX), .W(CW)) u_pos (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (in_acc),
    .last (in_eof),
    .pos  (pos)
  );

  always_comb begin
    st_d      = st;
    hold_d    = hold_q;
    hit_d     = tag_hit;
    tag_d     = tag_val;
    in_ready  = out_ready;
    out_valid = in_valid;
    out_data  = in_data;
    out_sof   = in_sof;
    out_eof   = in_eof;
    unique case (st)
      RX_PASS: begin
        if (strip_en && in_valid && !in_eof && pos == CW'(HDR)) begin
          in_ready  = 1'b1;
          out_valid = 1'b0;
          hold_d    = in_data;
          st_d      = RX_HOLD;
        end
      end
      RX_HOLD: begin
        out_sof = 1'b0;
        out_eof = 1'b0;
        if (!in_valid) begin
          in_ready  = 1'b0;
          out_valid = 1'b0;
        end else if (tpid_match) begin
          in_ready  = 1'b1;
          out_valid = 1'b0;
          hit_d     = 1'b1;
          st_d      = RX_DROP;
        end else begin
          in_ready  = 1'b0;
          out_valid = 1'b1;
          out_data  = hold_q;
          if (out_ready)
            st_d = RX_PASS;
        end
      end
      RX_DROP: begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        if (in_valid) begin
          if (pos == CW'(HDR + 2))
            tag_d[15:8] = in_data;
          else
            tag_d[7:0] = in_data;
          if (pos == CW'(HDR + 3) || in_eof)
            st_d = RX_PASS;
        end
      end
      default: st_d = RX_PASS;
    endcase
    if (in_valid && in_ready && in_sof) begin
      hit_d = 1'b0;
      tag_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_PASS;
      hold_q  <= '0;
      tag_hit <= 1'b0;
      tag_val <= '0;
    end else begin
      st      <= st_d;
      hold_q  <= hold_d;
      tag_hit <= hit_d;
      tag_val <= tag_d;
    end
  end

  AST_RX_HIT_ENTERS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_hit) |-> (st == RX_DROP)); // R6

  AST_RX_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_DROP) |-> !out_valid); // R5

  AST_RX_SHORT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && in_eof && pos < CW'(HDR + 1)) |=> !tag_hit); // R8

  AST_RX_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_HOLD && out_valid && !out_ready) |=> (out_valid && out_data == $past(hold_q))); // R9

  AST_RX_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!strip_en && st == RX_PASS) |-> (out_valid == in_valid)); // R7

endmodule

// File: rtl/vlan_tag_unit.sv
module vlan_tag_unit #(
  parameter int          ADDR_BYTES = 6,
  parameter logic [15:0] TPID       = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  tx_in_data,
  input  logic        tx_in_valid,
  input  logic        tx_in_sof,
  input  logic        tx_in_eof,
  input  logic        tx_in_tag_en,
  input  logic [15:0] tx_in_tag,
  output logic        tx_in_ready,
  output logic [7:0]  tx_out_data,
  output logic        tx_out_valid,
  output logic        tx_out_sof,
  output logic        tx_out_eof,
  input  logic        tx_out_ready,
  input  logic        rx_strip_en,
  input  logic [7:0]  rx_in_data,
  input  logic        rx_in_valid,
  input  logic        rx_in_sof,
  input  logic        rx_in_eof,
  output logic        rx_in_ready,
  output logic [7:0]  rx_out_data,
  output logic        rx_out_valid,
  output logic        rx_out_sof,
  output logic        rx_out_eof,
  input  logic        rx_out_ready,
  output logic        rx_tag_hit,
  output logic [15:0] rx_tag
);

  localparam int HDR = 2 * ADDR_BYTES;

  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  vtag_tx_insert #(.HDR(HDR), .TPID(TPID)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_data  (tx_in_data),
    .in_valid (tx_in_valid),
    .in_sof   (tx_in_sof),
    .in_eof   (tx_in_eof),
    .in_tag_en(tx_in_tag_en),
    .in_tag   (tx_in_tag),
    .in_ready (tx_in_ready),
    .out_data (tx_out_data),
    .out_valid(tx_out_valid),
    .out_sof  (tx_out_sof),
    .out_eof  (tx_out_eof),
    .out_ready(tx_out_ready)
  );

  vtag_rx_strip #(.HDR(HDR), .TPID(TPID)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .strip_en (rx_strip_en),
    .in_data  (rx_in_data),
    .in_valid (rx_in_valid),
    .in_sof   (rx_in_sof),
    .in_eof   (rx_in_eof),
    .in_ready (rx_in_ready),
    .out_data (rx_out_data),
    .out_valid(rx_out_valid),
    .out_sof  (rx_out_sof),
    .out_eof  (rx_out_eof),
    .out_ready(rx_out_ready),
    .tag_hit  (rx_tag_hit),
    .tag_val  (rx_tag)
  );

endmodule

// File: tb/vlan_tag_unit_test.sv
module vlan_tag_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tx_in_data;
  logic        tx_in_valid, tx_in_sof, tx_in_eof, tx_in_tag_en;
  logic [15:0] tx_in_tag;
  logic        tx_in_ready;
  logic [7:0]  tx_out_data;
  logic        tx_out_valid, tx_out_sof, tx_out_eof, tx_out_ready;
  logic        rx_strip_en;
  logic [7:0]  rx_in_data;
  logic        rx_in_valid, rx_in_sof, rx_in_eof, rx_in_ready;
  logic [7:0]  rx_out_data;
  logic        rx_out_valid, rx_out_sof, rx_out_eof, rx_out_ready;
  logic        rx_tag_hit;
  logic [15:0] rx_tag;

  always #5 clk = ~clk;

  vlan_tag_unit uut (.*);

  int n_tests = 0;
  int n_fail  = 0;

  // {len[47:40], tx_en[39], rx_en[38], stall[37], pad[36:32], tag[31:16], type[15:0]}
  localparam logic [47:0] VEC [11] = '{
    {8'd20, 1'b1, 1'b1, 1'b0, 5'd0, 16'hA123, 16'h8100},
    {8'd20, 1'b0, 1'b1, 1'b0, 5'd0, 16'h0000, 16'h0800},
    {8'd12, 1'b1, 1'b0, 1'b0, 5'd0, 16'h5555, 16'h8100},
    {8'd13, 1'b1, 1'b1, 1'b0, 5'd0, 16'h1234, 16'h8100},
    {8'd14, 1'b1, 1'b1, 1'b1, 5'd0, 16'h4321, 16'h8100},
    {8'd30, 1'b1, 1'b1, 1'b1, 5'd0, 16'hEFFF, 16'h8100},
    {8'd24, 1'b1, 1'b0, 1'b1, 5'd0, 16'h0001, 16'h8100},
    {8'd24, 1'b0, 1'b1, 1'b1, 5'd0, 16'h2002, 16'h8101},
    {8'd17, 1'b1, 1'b1, 1'b0, 5'd0, 16'hFFFF, 16'h8100},
    {8'd40, 1'b1, 1'b1, 1'b1, 5'd0, 16'h6ABC, 16'h8100},
    {8'd18, 1'b0, 1'b1, 1'b1, 5'd0, 16'h7777, 16'h0081}
  };

  logic [7:0]  got [64];
  logic [7:0]  exp [64];
  int          got_n, exp_n, mark_bad, lat_bad, blk_beats;
  logic        got_hit, timed_out;
  logic [15:0] got_tag;

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 29 + i * 11 + 3) & 255);
  endfunction

  function automatic logic [7:0] rx_src(input int s, input int i, input logic [15:0] typ,
                                        input logic [15:0] tag);
    if (i == 12) return typ[15:8];
    if (i == 13) return typ[7:0];
    if (i == 14) return tag[15:8];
    if (i == 15) return tag[7:0];
    return pat(s, i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic cmp_frame(input string req);
    int first_bad;
    first_bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (first_bad < 0 && got[i] !== exp[i]) first_bad = i;
    chk(got_n == exp_n, req, "frame length", got_n, exp_n);
    if (first_bad >= 0)
      chk(1'b0, req, $sformatf("byte %0d", first_bad), got[first_bad], exp[first_bad]);
    else
      chk(1'b1, req, "bytes", 0, 0);
    chk(mark_bad == 0, req, "start/end markers (R9)", mark_bad, 0);
    chk(!timed_out, req, "watchdog", 1, 0);
  endtask

  task automatic run_tx(input int len, input bit en, input logic [15:0] tag, input bit stall, input int seed);
    int idx, cyc;
    bit pend, done, gap;
    idx = 0; cyc = 0; pend = 0; done = 0;
    got_n = 0; mark_bad = 0; lat_bad = 0; blk_beats = 0; timed_out = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      gap          = !pend && stall && (cyc % 5 == 3);
      tx_in_valid  = (idx < len) && !gap;
      tx_in_data   = pat(seed, idx);
      tx_in_sof    = (idx == 0);
      tx_in_eof    = (idx == len - 1);
      tx_in_tag_en = en;
      tx_in_tag    = tag;
      tx_out_ready = !(stall && (cyc % 3 == 1));
      #1;
      pend = tx_in_valid && !tx_in_ready;
      if (tx_out_valid !== tx_in_valid || (tx_in_valid && tx_out_data !== tx_in_data)) lat_bad++;
      if (tx_out_valid && tx_out_ready) begin
        if (!tx_in_ready) blk_beats++;
        if (tx_out_sof !== (got_n == 0)) mark_bad++;
        got[got_n] = tx_out_data;
        got_n++;
        if (tx_out_eof) done = 1;
        else if (got_n == 64) done = 1;
      end
      if (tx_in_valid && tx_in_ready) idx++;
    end
    if (!done) timed_out = 1;
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic run_rx(input int len, input bit en, input logic [15:0] typ, input logic [15:0] tag,
                        input bit stall, input int seed);
    int idx, cyc;
    bit pend, done, gap;
    idx = 0; cyc = 0; pend = 0; done = 0;
    got_n = 0; mark_bad = 0; lat_bad = 0; timed_out = 0;
    got_hit = 1'bx; got_tag = 'x;
    rx_strip_en = en;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      gap          = !pend && stall && (cyc % 4 == 2);
      rx_in_valid  = (idx < len) && !gap;
      rx_in_data   = rx_src(seed, idx, typ, tag);
      rx_in_sof    = (idx == 0);
      rx_in_eof    = (idx == len - 1);
      rx_out_ready = !(stall && (cyc % 3 == 0));
      #1;
      pend = rx_in_valid && !rx_in_ready;
      if (rx_out_valid !== rx_in_valid || (rx_in_valid && rx_out_data !== rx_in_data)) lat_bad++;
      if (rx_out_valid && rx_out_ready) begin
        if (rx_out_sof !== (got_n == 0)) mark_bad++;
        got[got_n] = rx_out_data;
        got_n++;
        if (rx_out_eof) begin
          done    = 1;
          got_hit = rx_tag_hit;
          got_tag = rx_tag;
        end else if (got_n == 64) done = 1;
      end
      if (rx_in_valid && rx_in_ready) idx++;
    end
    if (!done) timed_out = 1;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic check_idle(input string what);
    tx_out_ready = 1'b1;
    rx_out_ready = 1'b1;
    #1;
    chk(tx_out_valid === 1'b0 && rx_out_valid === 1'b0, "R10", {what, " output valids"},
        {tx_out_valid, rx_out_valid}, 0);
    chk(tx_in_ready === 1'b1 && rx_in_ready === 1'b1, "R10", {what, " input ready"},
        {tx_in_ready, rx_in_ready}, 3);
    chk(rx_tag_hit === 1'b0 && rx_tag === 16'h0, "R10", {what, " tag outputs"}, {rx_tag_hit, rx_tag}, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_in_valid = 0; tx_in_data = 0; tx_in_sof = 0; tx_in_eof = 0; tx_in_tag_en = 0; tx_in_tag = 0;
    rx_in_valid = 0; rx_in_data = 0; rx_in_sof = 0; rx_in_eof = 0; rx_strip_en = 0;
    tx_out_ready = 1; rx_out_ready = 1;
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("after reset");

    // Table-driven frames through both paths.
    for (int v = 0; v < 11; v++) begin
      int          len;
      bit          txen, rxen, stall, strip;
      logic [15:0] tag, typ;
      string       req;
      len   = int'(VEC[v][47:40]);
      txen  = VEC[v][39];
      rxen  = VEC[v][38];
      stall = VEC[v][37];
      tag   = VEC[v][31:16];
      typ   = VEC[v][15:0];

      // Transmit expectation
      exp_n = 0;
      for (int i = 0; i < len; i++) begin
        if (txen && i == 12) begin
          exp[exp_n] = 8'h81;       exp_n++;
          exp[exp_n] = 8'h00;       exp_n++;
          exp[exp_n] = tag[15:8];   exp_n++;
          exp[exp_n] = tag[7:0];    exp_n++;
        end
        exp[exp_n] = pat(v, i);
        exp_n++;
      end
      req = (txen && len > 12) ? "R1/R2" : (txen ? "R4" : "R3");
      run_tx(len, txen, tag, stall, v);
      cmp_frame(stall ? {req, "+R9"} : req);
      if (!txen && !stall) chk(lat_bad == 0, "R3", "zero-delay pass", lat_bad, 0);
      if (txen && len > 12 && !stall) chk(blk_beats == 4, "R11", "blocked output beats", blk_beats, 4);

      // Receive expectation
      strip = rxen && typ == 16'h8100 && len >= 17;
      exp_n = 0;
      for (int i = 0; i < len; i++) begin
        if (!(strip && i >= 12 && i <= 15)) begin
          exp[exp_n] = rx_src(v, i, typ, tag);
          exp_n++;
        end
      end
      req = strip ? "R5" : (len <= 14 ? "R8" : "R7");
      run_rx(len, rxen, typ, tag, stall, v);
      cmp_frame(stall ? {req, "+R9"} : req);
      if (strip)
        chk(got_hit === 1'b1 && got_tag === tag, "R6", "tag report", {got_hit, got_tag}, {1'b1, tag});
      else
        chk(got_hit === 1'b0 && got_tag === 16'h0, req, "no tag report", {got_hit, got_tag}, 0);
      if (!rxen && !stall) chk(lat_bad == 0, "R7", "zero-delay pass when disabled", lat_bad, 0);
    end

    // Reset in the middle of an insertion and a strip.
    @(negedge clk);
    tx_in_valid = 1; tx_in_sof = 1; tx_in_eof = 0; tx_in_tag_en = 1; tx_in_tag = 16'hBEEF;
    rx_strip_en = 1; rx_in_valid = 1; rx_in_sof = 1; rx_in_eof = 0; rx_in_data = 8'h11;
    tx_out_ready = 1; rx_out_ready = 1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      tx_in_sof = 0; rx_in_sof = 0;
      rx_in_data = (i == 11) ? 8'h81 : (i == 12) ? 8'h00 : 8'h22;
    end
    tx_in_valid = 0; rx_in_valid = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("mid-frame reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("released after mid-frame reset");

    // Clean frame after the mid-frame reset: no residue of the broken frame.
    exp_n = 0;
    for (int i = 0; i < 16; i++) begin
      exp[exp_n] = pat(50, i);
      exp_n++;
    end
    run_tx(16, 1'b0, 16'h0, 1'b0, 50);
    cmp_frame("R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule